// File: doc/BRIEF.md
# EEPROM Software Write-Protect Controller

This block holds the software write-protection state of a small serial EEPROM and decides, for each array address, whether a write may proceed. It sits behind the serial bus front end. That front end hands it fully decoded transactions: a device address byte, a word address byte and a data byte, presented together with `cmd_valid`.

A transaction addressed to the protection register either loads new protection settings or requests the register's read image. A write is refused when its fixed data bits are malformed, when its lock-confirmation copy disagrees with the lock bit, or when the register has already been locked. Once the lock is set, the settings can no longer change.

The array write path presents an address and receives a combinational allow signal. A one-cycle flag reports each array write that protection refused. The command input accepts one transaction per cycle with `cmd_ready` held high, so it never applies back-pressure. Read results appear as a one-cycle `rd_valid` pulse that the consumer must take when it arrives.

Top module: `wp_guard`

## Requirements
- R1: After a synchronous active-low reset, `wp_image` is 0x00 (enable 0, block select 00, lock 0), every array address is allowed, and `reg_reject`, `rd_valid` and `arr_blocked` are low.
- R2: A command addresses the register only when `cmd_dev[7:4]` is 1011, `cmd_dev[2]` equals `hw_a2`, and `cmd_dev[1]` equals `hw_a1` (this last test is skipped when `MASK_A1` is 1). `cmd_dev[3]` is ignored, and `cmd_dev[0]` selects read (1) or write (0). Other commands change nothing and raise no flag.
- R3: A register command also needs `cmd_word[7:6]` to be 11, with `cmd_word[5:0]` ignored. Otherwise it is dropped silently.
- R4: A register read pulses `rd_valid` for one cycle on the cycle after the command. `rd_data` then carries the image, and no write takes place.
- R5: `wp_image` is always {4'b0000, enable, block select[1:0], lock}.
- R6: A register write whose data does not have bit 7 = 0, bit 6 = 1 and bit 4 = 0 leaves the image unchanged and pulses `reg_reject` on the next cycle.
- R7: A register write whose data bit 5 differs from data bit 0 is aborted. The image is kept and `reg_reject` pulses.
- R8: An accepted write loads enable, block select and lock from data bits 3, 2:1 and 0. The new image is visible on the cycle after the command.
- R9: Once lock is 1, every later register write is refused with a `reg_reject` pulse and the image never changes again.
- R10: With enable 0, `arr_allow` is 1 for every address, whatever the block select holds.
- R11: With enable 1, the protected region is the top 1/4, 1/2, 3/4 or all of the `ARRAY_BYTES` array for block select 00, 01, 10 or 11. Protected addresses drive `arr_allow` low.
- R12: `arr_blocked` is high for exactly the one cycle after a cycle with `arr_wr` high and `arr_allow` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_a2 | input | 1 | Strapped hardware address bit 2 |
| hw_a1 | input | 1 | Strapped hardware address bit 1 |
| cmd_valid | input | 1 | Decoded transaction present |
| cmd_ready | output | 1 | Always 1; transactions are never stalled |
| cmd_dev | input | 8 | Device address byte |
| cmd_word | input | 8 | Word address byte |
| cmd_data | input | 8 | Write data byte |
| rd_valid | output | 1 | One-cycle pulse carrying a register read result |
| rd_data | output | 8 | Read image returned by a register read |
| wp_image | output | 8 | Live register image |
| reg_reject | output | 1 | Pulse: register write refused |
| arr_addr | input | AW | Array address under test |
| arr_wr | input | 1 | Array write strobe |
| arr_allow | output | 1 | Address may be written |
| arr_blocked | output | 1 | Pulse: array write refused by protection |

## Verification
The hardest state to reach is the locked register. It is permanent, so it can be tested only after every unlocked behaviour has been covered. The stimulus therefore orders its vector table so that the lock is set near the end, after the malformed, mismatched and unaddressed writes have been tried. The attempted overwrites come last. A mid-run reset then returns the block to its reset image. The rejection paths also need the two lock-confirmation mismatch polarities, and each of these is a dedicated vector.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1011;
  localparam logic [1:0] WORD_TAG = 2'b11;

  typedef struct packed {
    logic       en;
    logic [1:0] sel;
    logic       lock;
  } wp_state_t;

  function automatic logic [7:0] image_of(wp_state_t s);
    return {4'b0000, s.en, s.sel, s.lock};
  endfunction
endpackage

// File: rtl/wpg_decode.sv
module wpg_decode #(
  parameter bit MASK_A1 = 1'b0
) (
  input  logic       cmd_valid,
  input  logic [7:0] cmd_dev,
  input  logic [7:0] cmd_word,
  input  logic [4:0] data_ctl,   // {d7,d6,d5,d4,d0}
  input  logic       hw_a2,
  input  logic       hw_a1,
  output logic       wr_hit,
  output logic       rd_hit,
  output logic       fmt_ok,
  output logic       confirm_ok
);
  import wpg_pkg::*;

  logic a1_ok;
  logic addr_hit;
  logic unused_bits;

  generate
    if (MASK_A1) begin : g_a1_masked
      assign a1_ok = 1'b1;
    end else begin : g_a1_checked
      assign a1_ok = (cmd_dev[1] == hw_a1);
    end
  endgenerate

  assign addr_hit = cmd_valid
                  && (cmd_dev[7:4] == DEV_CODE)
                  && (cmd_dev[2] == hw_a2)
                  && a1_ok
                  && (cmd_word[7:6] == WORD_TAG);

  assign wr_hit     = addr_hit && !cmd_dev[0];
  assign rd_hit     = addr_hit &&  cmd_dev[0];
  assign fmt_ok     = (data_ctl[4] == 1'b0) && (data_ctl[3] == 1'b1) && (data_ctl[1] == 1'b0);
  assign confirm_ok = (data_ctl[2] == data_ctl[0]);

  assign unused_bits = ^{cmd_dev[3], cmd_word[5:0], hw_a1};
endmodule

// File: rtl/wpg_reg.sv
module wpg_reg (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_hit,
  input  logic                 fmt_ok,
  input  logic                 confirm_ok,
  input  logic [3:0]           new_bits,
  output wpg_pkg::wp_state_t   state,
  output logic                 reject
);
  import wpg_pkg::*;

  logic refuse;
  assign refuse = state.lock || !fmt_ok || !confirm_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= '0;
      reject <= 1'b0;
    end else begin
      reject <= 1'b0;
      if (wr_hit) begin
        if (refuse) begin
          reject <= 1'b1;
        end else begin
          state <= wp_state_t'(new_bits);
        end
      end
    end
  end
endmodule

// File: rtl/wpg_region.sv
module wpg_region #(
  parameter int AW = 9
) (
  input  logic          en,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] addr,
  output logic          allow
);
  logic [1:0] quarter;
  logic [1:0] first_q;
  logic       unused_low;

  assign quarter = addr[AW-1 -: 2];
  // lowest protected quarter: 3 for sel 00 down to 0 for sel 11
  assign first_q = 2'd3 - sel;
  assign allow   = !(en && (quarter >= first_q));

  generate
    if (AW > 2) begin : g_low
      assign unused_low = ^addr[AW-3:0];
    end else begin : g_nolow
      assign unused_low = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int ARRAY_BYTES = 512,
  parameter bit MASK_A1     = 1'b0,
  localparam int AW         = $clog2(ARRAY_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_a2,
  input  logic          hw_a1,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [7:0]    cmd_dev,
  input  logic [7:0]    cmd_word,
  input  logic [7:0]    cmd_data,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic [7:0]    wp_image,
  output logic          reg_reject,
  input  logic [AW-1:0] arr_addr,
  input  logic          arr_wr,
  output logic          arr_allow,
  output logic          arr_blocked
);
  import wpg_pkg::*;

  logic      wr_hit, rd_hit, fmt_ok, confirm_ok;
  wp_state_t state;

  assign cmd_ready = 1'b1;

  wpg_decode #(.MASK_A1(MASK_A1)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_dev   (cmd_dev),
    .cmd_word  (cmd_word),
    .data_ctl  ({cmd_data[7:4], cmd_data[0]}),
    .hw_a2     (hw_a2),
    .hw_a1     (hw_a1),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit),
    .fmt_ok    (fmt_ok),
    .confirm_ok(confirm_ok)
  );

  wpg_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .fmt_ok    (fmt_ok),
    .confirm_ok(confirm_ok),
    .new_bits  (cmd_data[3:0]),
    .state     (state),
    .reject    (reg_reject)
  );

  wpg_region #(.AW(AW)) u_rgn (
    .en   (state.en),
    .sel  (state.sel),
    .addr (arr_addr),
    .allow(arr_allow)
  );

  assign wp_image = image_of(state);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      arr_blocked <= 1'b0;
    end else begin
      rd_valid    <= rd_hit;
      if (rd_hit) rd_data <= wp_image;
      arr_blocked <= arr_wr && !arr_allow;
    end
  end
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [7:0]    wp_image,
  input logic          reg_reject,
  input logic          rd_valid,
  input logic [AW-1:0] arr_addr,
  input logic          arr_wr,
  input logic          arr_allow,
  input logic          arr_blocked
);
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wp_image[7:4] == 4'b0000);

  a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wp_image[0] |=> (wp_image[0] && $stable(wp_image)));

  a_r6_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    reg_reject |-> $stable(wp_image));

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(wp_image));

  a_r4_no_read_reject: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && reg_reject));

  a_r10_disabled_allows: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_image[3] |-> arr_allow);

  a_r11_all_protected: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_image[3:1] == 3'b111) |-> !arr_allow);

  a_r12_block_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr && !arr_allow) |=> arr_blocked);

  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_wr && !arr_allow) |=> !arr_blocked);

  logic unused_addr;
  assign unused_addr = ^arr_addr;
endmodule

bind wp_guard wpg_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .wp_image   (wp_image),
  .reg_reject (reg_reject),
  .rd_valid   (rd_valid),
  .arr_addr   (arr_addr),
  .arr_wr     (arr_wr),
  .arr_allow  (arr_allow),
  .arr_blocked(arr_blocked)
);

// File: tb/wp_guard_test.sv
`timescale 1ns/1ps
module wp_guard_test;
  localparam int N  = 512;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_dev = '0, cmd_word = '0, cmd_data = '0;
  logic [AW-1:0] arr_addr = '0;
  logic arr_wr = 1'b0;
  logic cmd_ready, rd_valid, reg_reject, arr_allow, arr_blocked;
  logic [7:0] rd_data, wp_image;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  wp_guard #(.ARRAY_BYTES(N), .MASK_A1(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .hw_a2(1'b1), .hw_a1(1'b0),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dev(cmd_dev), .cmd_word(cmd_word), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .wp_image(wp_image),
    .reg_reject(reg_reject), .arr_addr(arr_addr), .arr_wr(arr_wr),
    .arr_allow(arr_allow), .arr_blocked(arr_blocked)
  );

  // {dev, word, data, expected image, expected reject}
  localparam int NV = 15;
  localparam logic [32:0] VEC [NV] = '{
    {8'hB4, 8'hC0, 8'h4A, 8'h0A, 1'b0},  // R8 accepted write
    {8'hA4, 8'hC0, 8'h4E, 8'h0A, 1'b0},  // R2 wrong device code
    {8'hB6, 8'hC0, 8'h4E, 8'h0A, 1'b0},  // R2 A1 mismatch
    {8'hBC, 8'hFF, 8'h4E, 8'h0E, 1'b0},  // R2 bit3 ignored, R3 low bits ignored
    {8'hB4, 8'h80, 8'h48, 8'h0E, 1'b0},  // R3 word tag wrong
    {8'hB4, 8'hC0, 8'hCE, 8'h0E, 1'b1},  // R6 bit7 set
    {8'hB4, 8'hC0, 8'h0E, 8'h0E, 1'b1},  // R6 bit6 clear
    {8'hB4, 8'hC0, 8'h5E, 8'h0E, 1'b1},  // R6 bit4 set
    {8'hB4, 8'hC0, 8'h41, 8'h0E, 1'b1},  // R7 lock without confirm
    {8'hB4, 8'hC0, 8'h60, 8'h0E, 1'b1},  // R7 confirm without lock
    {8'hB4, 8'hC0, 8'h44, 8'h04, 1'b0},  // R8 enable off
    {8'hB5, 8'hC0, 8'h4E, 8'h04, 1'b0},  // R4 read does not write
    {8'hB4, 8'hC0, 8'h6B, 8'h0B, 1'b0},  // R9 lock set
    {8'hB4, 8'hC0, 8'h40, 8'h0B, 1'b1},  // R9 locked refuse
    {8'hB4, 8'hC0, 8'h6F, 8'h0B, 1'b1}   // R9 locked refuse
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic txn(logic [7:0] d, logic [7:0] w, logic [7:0] x);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dev = d; cmd_word = w; cmd_data = x;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic exp_allow(logic en, int sel, int a);
    return !(en && (a >= (3 - sel) * (N / 4)));
  endfunction

  task automatic region_sweep(logic en, int sel, string req);
    int pts [8] = '{0, N/4-1, N/4, N/2-1, N/2, 3*N/4-1, 3*N/4, N-1};
    for (int k = 0; k < 8; k++) begin
      arr_addr = pts[k][AW-1:0];
      #1;
      chk(req, 32'(arr_allow), 32'(exp_allow(en, sel, pts[k])));
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 image", 32'(wp_image), 32'h00);
    chk("R1 reject", 32'(reg_reject), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 blocked", 32'(arr_blocked), 0);
    chk("R1 ready", 32'(cmd_ready), 1);
    region_sweep(1'b0, 0, "R1 allow");

    // R10 enable off with select 11
    txn(8'hB4, 8'hC0, 8'h46);
    chk("R10 image", 32'(wp_image), 32'h06);
    region_sweep(1'b0, 3, "R10 allow");

    // R11 each block select
    for (int s = 0; s < 4; s++) begin
      txn(8'hB4, 8'hC0, {4'b0100, 1'b1, 2'(s), 1'b0});
      chk("R8 sweep image", 32'(wp_image), 32'({4'b0000, 1'b1, 2'(s), 1'b0}));
      region_sweep(1'b1, s, "R11 allow");
    end

    // R12 blocked pulse (select 00 active)
    txn(8'hB4, 8'hC0, 8'h48);
    @(negedge clk);
    arr_addr = AW'(3*N/4); arr_wr = 1'b1;
    @(negedge clk);
    arr_wr = 1'b0;
    chk("R12 blocked pulse", 32'(arr_blocked), 1);
    @(negedge clk);
    chk("R12 pulse ends", 32'(arr_blocked), 0);
    arr_addr = AW'(10); arr_wr = 1'b1;
    @(negedge clk);
    arr_wr = 1'b0;
    chk("R12 allowed write", 32'(arr_blocked), 0);

    // R4 read
    txn(8'hB5, 8'hC0, 8'h00);
    chk("R4 rd_valid", 32'(rd_valid), 1);
    chk("R4 rd_data", 32'(rd_data), 32'h08);
    chk("R5 image format", 32'(wp_image), 32'h08);
    @(negedge clk);
    chk("R4 pulse ends", 32'(rd_valid), 0);
    txn(8'hB5, 8'h40, 8'h00);
    chk("R3 read ignored", 32'(rd_valid), 0);

    // vector table (ends locked)
    for (int i = 0; i < NV; i++) begin
      txn(VEC[i][32:25], VEC[i][24:17], VEC[i][16:9]);
      chk("R8 table image", 32'(wp_image), 32'(VEC[i][8:1]));
      chk("R6 table reject", 32'(reg_reject), 32'(VEC[i][0]));
    end

    // R9 locked: region still enforced, image fixed
    region_sweep(1'b1, 1, "R9 locked region");
    txn(8'hB4, 8'hC0, 8'h47);
    chk("R9 locked unlock attempt", 32'(wp_image), 32'h0B);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 image after reset", 32'(wp_image), 32'h00);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule